// File: doc/BRIEF.md
# SPI Flash Address-Width Mode Synchronizer

This block keeps the single bit that tells an SPI flash device interface whether addresses on the wire are three bytes (mode 0) or four bytes (mode 1). The bit is owned by two clock domains. Software in the system clock domain can request a mode. Host commands seen in the SPI clock domain (enter four-byte and exit four-byte) can also change it. The SPI clock is gated and only toggles while a transaction is in progress.

A software request is not applied the moment it is written. It is carried across as a toggle plus a held value and waits in the SPI domain. It is taken only on the command sync pulse, the SPI edge that delivers the eighth bit of an opcode. The new mode therefore governs the address phase of that same transaction. The SPI domain drives two copies of the mode. One is registered and serves the passthrough path. The other is the next-state value and serves the upload path, so the upload path sees a new mode in the very cycle it is committed.

Towards software the block reports a pending flag and a readback bit. While a request is waiting, the readback bit shows the requested value. Otherwise it shows the mode held in the SPI domain, brought back through a synchronizer.

Top module: `flash_amode_cdc`

## Requirements
- R1: After either reset is applied, the registered mode, the early mode, the readback bit and the pending flag are all 0 (three-byte addressing).
- R2: A software write sets the pending flag one system clock after the write strobe, even when the written value equals the current mode. While pending, the readback bit returns the most recently written value.
- R3: The registered SPI mode changes only on an SPI edge that carries the sync pulse or a command pulse. It does not change on other edges, and it does not change while the SPI clock is stopped.
- R4: On the edge that carries the sync pulse with a software request waiting, the early output shows the requested mode before that edge, and the registered output shows it after that edge.
- R5: Once a request has been committed, the pending flag clears and the readback bit shows the committed mode no later than three system clock cycles after the last SPI edge of the transaction.
- R6: An enter pulse sets the mode to 1 and an exit pulse sets it to 0 on the SPI edge that carries it. Enter wins if both are present. The readback bit follows within three system clock cycles after the transaction ends.
- R7: A command pulse that arrives while a software request is waiting overrides it. The mode takes the command's result, the pending flag clears, and the discarded value is not committed by any later sync pulse.
- R8: If software writes again while a request is still waiting, the value committed at the next sync pulse is the last one written.
- R9: A sync pulse with no software request waiting leaves the mode unchanged, and the early output then equals the registered output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk_i | input | 1 | System clock, free running |
| sys_rst_ni | input | 1 | System domain reset, asynchronous, active low |
| sw_wr_i | input | 1 | Software write strobe for the requested mode |
| sw_mode_i | input | 1 | Requested mode (1 = four-byte) |
| sw_mode_o | output | 1 | Readback bit: the waiting request if pending, else the SPI-held mode |
| sw_pending_o | output | 1 | A software request has not yet been taken by the SPI domain |
| spi_clk_i | input | 1 | SPI clock, gated, runs only during transactions |
| spi_rst_ni | input | 1 | SPI domain reset, asynchronous, active low |
| cmd_sync_i | input | 1 | Opcode eighth-bit pulse, the commit point for software requests |
| enter4b_i | input | 1 | Enter four-byte command pulse |
| exit4b_i | input | 1 | Exit four-byte command pulse |
| spi_mode_q_o | output | 1 | Registered committed mode (passthrough path) |
| spi_mode_early_o | output | 1 | Next-state mode, visible in the commit cycle (upload path) |

## Verification
The hardest situation to reach is a command pulse meeting a software request that is still waiting. That request must then be dropped for good, not committed by a later sync pulse. The bench writes a value while the SPI clock is stopped and runs seven plain opcode edges so the request is fully across. It then delivers the eighth edge with both the sync pulse and an enter pulse. A second transaction with a bare sync pulse follows, to show the discarded value never lands. The same stopped-clock approach lets the bench inspect the early output half a cycle before the commit edge, and then the registered output after it.

// File: rtl/flash_amode_pkg.sv
package flash_amode_pkg;

   typedef enum logic {
      AMODE_3B = 1'b0,
      AMODE_4B = 1'b1
   } amode_e;

   localparam int unsigned MinSyncStages = 2;

   // Priority of mode sources on one SPI edge: enter, then exit, then a
   // software request taken at the sync pulse, otherwise hold.
   function automatic logic amode_next(input logic cur,
                                       input logic sw_take,
                                       input logic sw_val,
                                       input logic enter,
                                       input logic leave);
      logic nxt;
      if (enter)        nxt = AMODE_4B;
      else if (leave)   nxt = AMODE_3B;
      else if (sw_take) nxt = sw_val;
      else              nxt = cur;
      return nxt;
   endfunction

endpackage

// File: rtl/flash_amode_sync.sv
module flash_amode_sync #(
   parameter int unsigned          WIDTH   = 1,
   parameter int unsigned          STAGES  = 2,
   parameter logic [WIDTH-1:0]     RST_VAL = '0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   import flash_amode_pkg::*;

   if (STAGES < MinSyncStages) begin : g_bad_depth
      $error("flash_amode_sync: STAGES must be at least %0d", MinSyncStages);
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("flash_amode_sync: WIDTH must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
      else         chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/flash_amode_sys.sv
module flash_amode_sys #(
   parameter int unsigned STAGES = 2
) (
   input  logic sys_clk_i,
   input  logic sys_rst_ni,
   input  logic wr_i,
   input  logic wr_mode_i,
   input  logic ack_tog_i,    // SPI domain, asynchronous here
   input  logic spi_mode_i,   // SPI domain, asynchronous here
   output logic req_tog_o,
   output logic req_mode_o,
   output logic rd_mode_o,
   output logic pending_o
);
   import flash_amode_pkg::*;

   localparam int unsigned BackW = 2;

   logic [BackW-1:0] back_seen;
   logic             ack_seen;
   logic             mode_seen;
   logic             req_tog_q;
   logic             req_mode_q;
   logic             outstanding;

   flash_amode_sync #(
      .WIDTH   (BackW),
      .STAGES  (STAGES),
      .RST_VAL ({1'b0, AMODE_3B})
   ) u_back_sync (
      .clk_i  (sys_clk_i),
      .rst_ni (sys_rst_ni),
      .d_i    ({ack_tog_i, spi_mode_i}),
      .q_o    (back_seen)
   );

   assign ack_seen    = back_seen[1];
   assign mode_seen   = back_seen[0];
   assign outstanding = req_tog_q ^ ack_seen;

   // A new toggle is launched only when nothing is outstanding; a write on
   // top of an outstanding request just replaces the held value.
   always_ff @(posedge sys_clk_i or negedge sys_rst_ni) begin
      if (!sys_rst_ni) begin
         req_tog_q  <= 1'b0;
         req_mode_q <= AMODE_3B;
      end else if (wr_i) begin
         req_mode_q <= wr_mode_i;
         if (!outstanding) req_tog_q <= ~req_tog_q;
      end
   end

   assign req_tog_o  = req_tog_q;
   assign req_mode_o = req_mode_q;
   assign pending_o  = outstanding;
   assign rd_mode_o  = outstanding ? req_mode_q : mode_seen;

endmodule

// File: rtl/flash_amode_spi.sv
module flash_amode_spi #(
   parameter int unsigned STAGES = 2
) (
   input  logic spi_clk_i,
   input  logic spi_rst_ni,
   input  logic req_tog_i,    // system domain, asynchronous here
   input  logic req_mode_i,   // system domain, asynchronous here
   input  logic sync_i,
   input  logic enter_i,
   input  logic leave_i,
   output logic mode_q_o,
   output logic mode_d_o,
   output logic ack_tog_o
);
   import flash_amode_pkg::*;

   localparam int unsigned FwdW = 2;

   logic [FwdW-1:0] fwd_seen;
   logic            tog_seen;
   logic            val_seen;
   logic            ack_q;
   logic            mode_q;
   logic            mode_d;
   logic            req_new;
   logic            any_evt;

   flash_amode_sync #(
      .WIDTH   (FwdW),
      .STAGES  (STAGES),
      .RST_VAL ({1'b0, AMODE_3B})
   ) u_fwd_sync (
      .clk_i  (spi_clk_i),
      .rst_ni (spi_rst_ni),
      .d_i    ({req_tog_i, req_mode_i}),
      .q_o    (fwd_seen)
   );

   assign tog_seen = fwd_seen[1];
   assign val_seen = fwd_seen[0];
   assign req_new  = tog_seen ^ ack_q;
   assign any_evt  = sync_i | enter_i | leave_i;

   assign mode_d = amode_next(mode_q, sync_i & req_new, val_seen,
                              enter_i, leave_i);

   always_ff @(posedge spi_clk_i or negedge spi_rst_ni) begin
      if (!spi_rst_ni) begin
         mode_q <= AMODE_3B;
         ack_q  <= 1'b0;
      end else begin
         mode_q <= mode_d;
         // A command pulse also retires a waiting request, discarding it.
         if (req_new && any_evt) ack_q <= tog_seen;
      end
   end

   assign mode_q_o  = mode_q;
   assign mode_d_o  = mode_d;
   assign ack_tog_o = ack_q;

endmodule

// File: rtl/flash_amode_cdc.sv
module flash_amode_cdc #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic sys_clk_i,
   input  logic sys_rst_ni,
   input  logic sw_wr_i,
   input  logic sw_mode_i,
   output logic sw_mode_o,
   output logic sw_pending_o,
   input  logic spi_clk_i,
   input  logic spi_rst_ni,
   input  logic cmd_sync_i,
   input  logic enter4b_i,
   input  logic exit4b_i,
   output logic spi_mode_q_o,
   output logic spi_mode_early_o
);
   import flash_amode_pkg::*;

   if (SYNC_STAGES < MinSyncStages) begin : g_bad_stages
      $error("flash_amode_cdc: SYNC_STAGES below %0d", MinSyncStages);
   end

   logic req_tog;
   logic req_mode;
   logic ack_tog;
   logic mode_q;

   flash_amode_sys #(
      .STAGES (SYNC_STAGES)
   ) u_sys (
      .sys_clk_i  (sys_clk_i),
      .sys_rst_ni (sys_rst_ni),
      .wr_i       (sw_wr_i),
      .wr_mode_i  (sw_mode_i),
      .ack_tog_i  (ack_tog),
      .spi_mode_i (mode_q),
      .req_tog_o  (req_tog),
      .req_mode_o (req_mode),
      .rd_mode_o  (sw_mode_o),
      .pending_o  (sw_pending_o)
   );

   flash_amode_spi #(
      .STAGES (SYNC_STAGES)
   ) u_spi (
      .spi_clk_i  (spi_clk_i),
      .spi_rst_ni (spi_rst_ni),
      .req_tog_i  (req_tog),
      .req_mode_i (req_mode),
      .sync_i     (cmd_sync_i),
      .enter_i    (enter4b_i),
      .leave_i    (exit4b_i),
      .mode_q_o   (mode_q),
      .mode_d_o   (spi_mode_early_o),
      .ack_tog_o  (ack_tog)
   );

   assign spi_mode_q_o = mode_q;

endmodule

// File: rtl/flash_amode_cdc_chk.sv
module flash_amode_cdc_chk (
   input logic sys_clk_i,
   input logic sys_rst_ni,
   input logic sw_wr_i,
   input logic sw_mode_i,
   input logic sw_mode_o,
   input logic sw_pending_o,
   input logic spi_clk_i,
   input logic spi_rst_ni,
   input logic cmd_sync_i,
   input logic enter4b_i,
   input logic exit4b_i,
   input logic spi_mode_q_o,
   input logic spi_mode_early_o
);

   // R3: no event on the edge, no change of the registered mode
   assert_hold_R3: assert property (@(posedge spi_clk_i) disable iff (!spi_rst_ni)
      !(cmd_sync_i || enter4b_i || exit4b_i) |=> $stable(spi_mode_q_o));

   // R6: enter forces four-byte mode
   assert_enter_R6: assert property (@(posedge spi_clk_i) disable iff (!spi_rst_ni)
      enter4b_i |=> spi_mode_q_o);

   // R6: exit alone forces three-byte mode
   assert_exit_R6: assert property (@(posedge spi_clk_i) disable iff (!spi_rst_ni)
      (exit4b_i && !enter4b_i) |=> !spi_mode_q_o);

   // R4, R9: early output departs from the register only on an event edge
   assert_early_R4: assert property (@(posedge spi_clk_i) disable iff (!spi_rst_ni)
      (spi_mode_early_o != spi_mode_q_o) |-> (cmd_sync_i || enter4b_i || exit4b_i));

   // R2: every write raises pending
   assert_pend_R2: assert property (@(posedge sys_clk_i) disable iff (!sys_rst_ni)
      sw_wr_i |=> sw_pending_o);

   // R2: readback returns the value just written
   assert_rdbk_R2: assert property (@(posedge sys_clk_i) disable iff (!sys_rst_ni)
      sw_wr_i |=> (sw_mode_o == $past(sw_mode_i)));

endmodule

bind flash_amode_cdc flash_amode_cdc_chk u_chk (
   .sys_clk_i        (sys_clk_i),
   .sys_rst_ni       (sys_rst_ni),
   .sw_wr_i          (sw_wr_i),
   .sw_mode_i        (sw_mode_i),
   .sw_mode_o        (sw_mode_o),
   .sw_pending_o     (sw_pending_o),
   .spi_clk_i        (spi_clk_i),
   .spi_rst_ni       (spi_rst_ni),
   .cmd_sync_i       (cmd_sync_i),
   .enter4b_i        (enter4b_i),
   .exit4b_i         (exit4b_i),
   .spi_mode_q_o     (spi_mode_q_o),
   .spi_mode_early_o (spi_mode_early_o)
);

// File: tb/flash_amode_cdc_tb.sv
module flash_amode_cdc_tb;

   logic sys_clk = 1'b0;
   logic sys_rst_n = 1'b0;
   logic sw_wr = 1'b0;
   logic sw_mode = 1'b0;
   logic sw_mode_rd;
   logic sw_pend;
   logic spi_clk = 1'b0;
   logic spi_rst_n = 1'b0;
   logic cmd_sync = 1'b0;
   logic en4b = 1'b0;
   logic ex4b = 1'b0;
   logic mode_q;
   logic mode_early;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   // 250 MHz system clock: 4 time-unit period
   always #2 sys_clk = ~sys_clk;

   flash_amode_cdc #(.SYNC_STAGES(2)) u_dut (
      .sys_clk_i        (sys_clk),
      .sys_rst_ni       (sys_rst_n),
      .sw_wr_i          (sw_wr),
      .sw_mode_i        (sw_mode),
      .sw_mode_o        (sw_mode_rd),
      .sw_pending_o     (sw_pend),
      .spi_clk_i        (spi_clk),
      .spi_rst_ni       (spi_rst_n),
      .cmd_sync_i       (cmd_sync),
      .enter4b_i        (en4b),
      .exit4b_i         (ex4b),
      .spi_mode_q_o     (mode_q),
      .spi_mode_early_o (mode_early)
   );

   task automatic check(input string req, input string what,
                        input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
      end
   endtask

   task automatic sys_write(input logic v);
      @(negedge sys_clk);
      sw_wr   = 1'b1;
      sw_mode = v;
      @(negedge sys_clk);
      sw_wr   = 1'b0;
   endtask

   task automatic spi_plain(input int n);
      for (int i = 0; i < n; i++) begin
         #5 spi_clk = 1'b1;
         #5 spi_clk = 1'b0;
      end
   endtask

   // One SPI edge carrying pulses; early checked before, register after
   task automatic spi_event(input logic s, input logic e, input logic x,
                            input logic exp, input string req);
      cmd_sync = s; en4b = e; ex4b = x;
      #2 check(req, "early before edge", mode_early, exp);
      #3 spi_clk = 1'b1;
      #2 check(req, "registered after edge", mode_q, exp);
      #3 spi_clk = 1'b0;
      cmd_sync = 1'b0; en4b = 1'b0; ex4b = 1'b0;
   endtask

   // Opcode phase (7 plain edges), the 8th edge, then an address phase
   task automatic spi_txn(input logic s, input logic e, input logic x,
                          input logic old_mode, input logic exp, input string req);
      spi_plain(7);
      check("R3", "no change on opcode edges 1..7", mode_q, old_mode);
      spi_event(s, e, x, exp, req);
      spi_plain(8);
   endtask

   task automatic settle();
      repeat (3) @(posedge sys_clk);
      #1;
   endtask

   task automatic do_reset();
      sys_rst_n = 1'b0;
      spi_rst_n = 1'b0;
      #10;
      check("R1", "registered mode in reset", mode_q, 1'b0);
      check("R1", "early mode in reset", mode_early, 1'b0);
      check("R1", "readback in reset", sw_mode_rd, 1'b0);
      check("R1", "pending in reset", sw_pend, 1'b0);
      @(negedge sys_clk);
      sys_rst_n = 1'b1;
      spi_rst_n = 1'b1;
      settle();
      check("R1", "pending after release", sw_pend, 1'b0);
      check("R1", "readback after release", sw_mode_rd, 1'b0);
   endtask

   task automatic t_sw_commit();
      sys_write(1'b1);
      check("R2", "pending after write", sw_pend, 1'b1);
      check("R2", "readback shows request", sw_mode_rd, 1'b1);
      settle();
      check("R3", "clock stopped, register held", mode_q, 1'b0);
      spi_txn(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R4");
      settle();
      check("R5", "pending cleared", sw_pend, 1'b0);
      check("R5", "readback committed", sw_mode_rd, 1'b1);
   endtask

   task automatic t_same_value();
      sys_write(1'b1);
      check("R2", "pending on equal-value write", sw_pend, 1'b1);
      spi_txn(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R4");
      settle();
      check("R5", "pending cleared after equal commit", sw_pend, 1'b0);
      check("R5", "readback after equal commit", sw_mode_rd, 1'b1);
   endtask

   task automatic t_idle_sync();
      spi_txn(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R9");
      check("R9", "early equals register", mode_early, mode_q);
      settle();
      check("R9", "readback unchanged", sw_mode_rd, 1'b1);
      check("R9", "no pending", sw_pend, 1'b0);
   endtask

   task automatic t_cmd_wins();
      sys_write(1'b0);
      check("R2", "readback shows request 0", sw_mode_rd, 1'b0);
      spi_txn(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, "R7");
      settle();
      check("R7", "pending cleared by command", sw_pend, 1'b0);
      check("R7", "readback matches command", sw_mode_rd, 1'b1);
      spi_txn(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R7");
      settle();
      check("R7", "discarded request never lands", sw_mode_rd, 1'b1);
   endtask

   task automatic t_enter_exit();
      spi_txn(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R6");
      settle();
      check("R6", "readback after exit", sw_mode_rd, 1'b0);
      spi_plain(7);
      spi_event(1'b0, 1'b1, 1'b0, 1'b1, "R6");
      spi_plain(4);
      settle();
      check("R6", "readback after enter", sw_mode_rd, 1'b1);
      spi_plain(7);
      spi_event(1'b1, 1'b1, 1'b1, 1'b1, "R6");
      spi_plain(2);
      settle();
   endtask

   task automatic t_overwrite();
      sys_write(1'b1);
      sys_write(1'b0);
      check("R8", "pending after overwrite", sw_pend, 1'b1);
      check("R8", "readback shows last write", sw_mode_rd, 1'b0);
      spi_txn(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R8");
      settle();
      check("R8", "last value committed", sw_mode_rd, 1'b0);
      check("R8", "pending cleared", sw_pend, 1'b0);
   endtask

   task automatic t_reset_pending();
      sys_write(1'b1);
      check("R2", "pending before reset", sw_pend, 1'b1);
      do_reset();
      spi_txn(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
      settle();
      check("R1", "cleared request not committed", sw_mode_rd, 1'b0);
   endtask

   initial begin
      #400000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      do_reset();
      t_sw_commit();
      t_same_value();
      t_idle_sync();
      t_cmd_wins();
      t_enter_exit();
      t_overwrite();
      t_reset_pending();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule